// File: doc/BRIEF.md
# Multicycle Load/Store Datapath

This block is the datapath half of a 32-bit multicycle processor core for a small load/store instruction subset: unsigned add and subtract, OR with an immediate, word load and store, branch when equal, and an absolute jump. It needs a separate control sequencer, which drives every select and write enable cycle by cycle. The datapath returns the opcode and the ALU zero flag to that sequencer.

Each instruction takes several clock cycles. A single memory port serves both instruction fetch and data access, and a single ALU handles PC increment, branch target, address and result arithmetic. The program counter, the instruction latch, the two operand latches, the ALU result latch and the memory data latch carry values from one step to the next. Operand, result and memory-data latches capture on every edge. The instruction latch captures only when told to.

The memory is combinational on reads and written on the rising edge while the write strobe is high. It lives outside the block.

Top module: `mcyc_datapath`

## Requirements
- R1: After reset the PC is 0, the instruction latch holds 0 (opcode_o reads 0), and with addr_sel_i=0 mem_addr_o is 0.
- R2: With addr_sel_i=0, mem_addr_o is the PC. The instruction latch loads mem_rdata_i only on an edge where ir_load_i=1 and holds otherwise. In a fetch step (alu_a_sel_i=0, alu_b_sel_i=01 constant four, alu_mode_i=00 add, pc_src_i=00 live ALU result, pc_we_i=1) the PC advances by 4.
- R3: alu_mode_i=10 takes the operation from instruction bits [5:0]: 0x23 subtracts, and 0x21 (or any other value) adds. Add and subtract wrap modulo 2^32 with no overflow indication.
- R4: With imm_zext_i=1 the 16-bit immediate is zero-extended. alu_mode_i=11 performs bitwise OR.
- R5: With imm_zext_i=0 the immediate (bits [15:0]) is sign-extended. Latch A (register rs, bits [25:21]) plus that value, selected by alu_a_sel_i=1 and alu_b_sel_i=10, forms the data address. With addr_sel_i=1 this address appears on mem_addr_o in the next step.
- R6: mem_wdata_o carries latch B, which is register rt (bits [20:16]). mem_we_o follows mem_we_i.
- R7: On an edge where reg_we_i=1, the register file is written. The destination is rt when wdst_sel_i=0 and rd (bits [15:11]) when wdst_sel_i=1. The data is the ALU latch when wdata_sel_i=0 and the memory data latch when wdata_sel_i=1.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: zero_o is high when the live ALU result is zero. The PC is written when pc_we_i=1, or when pc_we_cond_i=1 and zero_o=1. Otherwise it holds. pc_src_i=01 loads the ALU latch, which in a decode step (alu_b_sel_i=11) captures PC + (sign-extended immediate << 2).
- R10: pc_src_i=10 loads the jump target {PC[31:28], instruction bits [25:0], 2'b00}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Memory read data |
| addr_sel_i | input | 1 | Address source: 0 PC, 1 ALU latch |
| ir_load_i | input | 1 | Instruction latch enable |
| mem_we_i | input | 1 | Memory write request |
| reg_we_i | input | 1 | Register file write enable |
| wdst_sel_i | input | 1 | Destination: 0 rt, 1 rd |
| wdata_sel_i | input | 1 | Write data: 0 ALU latch, 1 memory data latch |
| alu_a_sel_i | input | 1 | ALU A: 0 PC, 1 latch A |
| alu_b_sel_i | input | 2 | ALU B: 00 latch B, 01 four, 10 immediate, 11 immediate<<2 |
| imm_zext_i | input | 1 | 1 zero-extends the immediate |
| alu_mode_i | input | 2 | 00 add, 01 subtract, 10 by function field, 11 OR |
| pc_src_i | input | 2 | 00 live ALU, 01 ALU latch, 10 jump target |
| pc_we_i | input | 1 | Unconditional PC write |
| pc_we_cond_i | input | 1 | PC write when zero_o |
| opcode_o | output | 6 | Instruction bits [31:26] |
| zero_o | output | 1 | Live ALU result is zero |

## Verification
The bench plays the sequencer and runs a short program against an instruction-level model. Every fetch address, every data address, every store value and every branch flag is compared as it occurs.

The arithmetic patterns are chosen to separate the operations. Adding 0xFFFF to 0xFFFFFFFF can only produce 0xFFFE if the sum wraps. Subtracting from register 0 checks that the borrow is carried across all 32 bits. An OR with 0x8001 shows whether the immediate was zero- or sign-extended. A load at a negative offset separates sign extension from zero extension in address formation.

For control flow, one branch is not taken and one is taken, which tells the zero-gated PC write apart from an unconditional one. A jump over dead stores shows whether the PC took the target or simply stepped by 4. A write to register 0 followed by a store of it shows that the write was discarded.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  typedef enum logic [1:0] {
    BSEL_REG    = 2'b00,
    BSEL_FOUR   = 2'b01,
    BSEL_IMM    = 2'b10,
    BSEL_IMM_SH = 2'b11
  } bsel_e;

  typedef enum logic [1:0] {
    AM_ADD   = 2'b00,
    AM_SUB   = 2'b01,
    AM_FUNCT = 2'b10,
    AM_OR    = 2'b11
  } alu_mode_e;

  typedef enum logic [1:0] {
    PCS_ALU   = 2'b00,
    PCS_LATCH = 2'b01,
    PCS_JUMP  = 2'b10,
    PCS_RSVD  = 2'b11
  } pc_src_e;

  localparam logic [5:0] FN_SUBU = 6'h23;
endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // entry 0 is hard zero on read
  assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   mode_i,
  input  logic [5:0]   funct_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    unique case (alu_mode_e'(mode_i))
      AM_ADD:   res_o = a_i + b_i;
      AM_SUB:   res_o = a_i - b_i;
      AM_FUNCT: res_o = (funct_i == FN_SUBU) ? (a_i - b_i) : (a_i + b_i);
      default:  res_o = a_i | b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mcyc_datapath.sv
module mcyc_datapath
  import mcyc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_we_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            addr_sel_i,
  input  logic            ir_load_i,
  input  logic            mem_we_i,
  input  logic            reg_we_i,
  input  logic            wdst_sel_i,
  input  logic            wdata_sel_i,
  input  logic            alu_a_sel_i,
  input  logic [1:0]      alu_b_sel_i,
  input  logic            imm_zext_i,
  input  logic [1:0]      alu_mode_i,
  input  logic [1:0]      pc_src_i,
  input  logic            pc_we_i,
  input  logic            pc_we_cond_i,
  output logic [5:0]      opcode_o,
  output logic            zero_o
);
  localparam int AW     = $clog2(NREG);
  localparam int IMM_W  = 16;
  localparam int JT_W   = 26;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, alu_q, mdr_q;
  logic [XLEN-1:0] rf_a, rf_b, alu_a, alu_b, alu_res, imm_ext, pc_next, rf_wd;
  logic [AW-1:0]   rs_f, rt_f, rd_f, rf_wa;
  logic            pc_load;
  logic            unused_shamt;

  assign rs_f = ir_q[RS_LSB +: AW];
  assign rt_f = ir_q[RT_LSB +: AW];
  assign rd_f = ir_q[RD_LSB +: AW];
  assign unused_shamt = ^ir_q[10:6];

  assign imm_ext = imm_zext_i ? {{(XLEN-IMM_W){1'b0}}, ir_q[IMM_W-1:0]}
                              : {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

  assign rf_wa = wdst_sel_i ? rd_f : rt_f;
  assign rf_wd = wdata_sel_i ? mdr_q : alu_q;

  mcyc_regfile #(.W(XLEN), .NREG(NREG)) i_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (rs_f),
    .ra_b_i (rt_f),
    .rd_a_o (rf_a),
    .rd_b_o (rf_b),
    .we_i   (reg_we_i),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd)
  );

  assign alu_a = alu_a_sel_i ? a_q : pc_q;

  always_comb begin
    unique case (bsel_e'(alu_b_sel_i))
      BSEL_REG:  alu_b = b_q;
      BSEL_FOUR: alu_b = XLEN'(4);
      BSEL_IMM:  alu_b = imm_ext;
      default:   alu_b = imm_ext << 2;
    endcase
  end

  mcyc_alu #(.W(XLEN)) i_alu (
    .a_i     (alu_a),
    .b_i     (alu_b),
    .mode_i  (alu_mode_i),
    .funct_i (ir_q[5:0]),
    .res_o   (alu_res),
    .zero_o  (zero_o)
  );

  always_comb begin
    unique case (pc_src_e'(pc_src_i))
      PCS_ALU:   pc_next = alu_res;
      PCS_LATCH: pc_next = alu_q;
      PCS_JUMP:  pc_next = {pc_q[XLEN-1:JT_W+2], ir_q[JT_W-1:0], 2'b00};
      default:   pc_next = pc_q;
    endcase
  end

  assign pc_load = pc_we_i | (pc_we_cond_i & zero_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
      mdr_q <= '0;
    end else begin
      if (pc_load)   pc_q <= pc_next;
      if (ir_load_i) ir_q <= mem_rdata_i;
      a_q   <= rf_a;
      b_q   <= rf_b;
      alu_q <= alu_res;
      mdr_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = addr_sel_i ? alu_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_we_o    = mem_we_i;
  assign opcode_o    = ir_q[XLEN-1:XLEN-6];

  assert_ir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_load_i |=> $stable(ir_q));

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_i && pc_src_i == 2'b00 && !alu_a_sel_i && alu_b_sel_i == 2'b01 && alu_mode_i == 2'b00)
    |=> (pc_q == $past(pc_q) + XLEN'(4)));

  assert_rs_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_f == '0) |=> (a_q == '0));

  assert_pc_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_we_i && !(pc_we_cond_i && zero_o)) |=> $stable(pc_q));

  assert_jump_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_i && pc_src_i == 2'b10)
    |=> (pc_q == {$past(pc_q[XLEN-1:JT_W+2]), $past(ir_q[JT_W-1:0]), 2'b00}));
endmodule

// File: tb/test_mcyc_datapath.sv
module test_mcyc_datapath;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic        addr_sel, ir_load, mem_we_c, reg_we, wdst_sel, wdata_sel, alu_a_sel;
  logic [1:0]  alu_b_sel, alu_mode, pc_src;
  logic        imm_zext, pc_we, pc_we_cond;
  logic [5:0]  opcode;
  logic        zero;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mcyc_datapath i_mcyc_datapath (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_rdata_i(mem_rdata),
    .addr_sel_i(addr_sel), .ir_load_i(ir_load), .mem_we_i(mem_we_c), .reg_we_i(reg_we),
    .wdst_sel_i(wdst_sel), .wdata_sel_i(wdata_sel), .alu_a_sel_i(alu_a_sel),
    .alu_b_sel_i(alu_b_sel), .imm_zext_i(imm_zext), .alu_mode_i(alu_mode),
    .pc_src_i(pc_src), .pc_we_i(pc_we), .pc_we_cond_i(pc_we_cond),
    .opcode_o(opcode), .zero_o(zero)
  );

  // behavioural memory, 64 words
  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

  // instruction-level reference state
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic clr();
    addr_sel = 0; ir_load = 0; mem_we_c = 0; reg_we = 0; wdst_sel = 0; wdata_sel = 0;
    alu_a_sel = 0; alu_b_sel = 2'b00; imm_zext = 0; alu_mode = 2'b00; pc_src = 2'b00;
    pc_we = 0; pc_we_cond = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] r_ins(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  localparam logic [5:0] OP_R = 6'h00, OP_ORI = 6'h0d, OP_LW = 6'h23, OP_SW = 6'h2b,
                         OP_BEQ = 6'h04, OP_J = 6'h02;
  localparam logic [5:0] F_ADD = 6'h21, F_SUB = 6'h23;

  task automatic run_one();
    logic [31:0] ins, sx, ea, av, bv;
    logic [5:0] op;
    int rs, rt, rd;
    ins = mmem[mpc[7:2]];
    op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx = {{16{ins[15]}}, ins[15:0]};
    av = mreg[rs]; bv = mreg[rt];
    ea = av + sx;
    // fetch: address is PC, which covers branch and jump targets (R2 R9 R10)
    clr(); ir_load = 1; alu_b_sel = 2'b01; pc_we = 1; #1;
    chk("R2 R9 R10 fetch address", mem_addr, mpc);
    tick();
    mpc = mpc + 4;
    // decode: branch target into ALU latch
    clr(); alu_b_sel = 2'b11; #1;
    chk("R2 opcode latched", {26'd0, opcode}, {26'd0, op});
    tick();
    case (op)
      OP_R: begin
        clr(); alu_a_sel = 1; alu_mode = 2'b10; tick();
        clr(); reg_we = 1; wdst_sel = 1; tick();
        if (rd != 0) mreg[rd] = (ins[5:0] == F_SUB) ? av - bv : av + bv;
      end
      OP_ORI: begin
        clr(); alu_a_sel = 1; alu_b_sel = 2'b10; imm_zext = 1; alu_mode = 2'b11; tick();
        clr(); reg_we = 1; tick();
        if (rt != 0) mreg[rt] = av | {16'd0, ins[15:0]};
      end
      OP_LW: begin
        clr(); alu_a_sel = 1; alu_b_sel = 2'b10; tick();
        clr(); addr_sel = 1; #1;
        chk("R5 load address", mem_addr, ea);
        tick();
        clr(); reg_we = 1; wdata_sel = 1; tick();
        if (rt != 0) mreg[rt] = mmem[ea[7:2]];
      end
      OP_SW: begin
        clr(); alu_a_sel = 1; alu_b_sel = 2'b10; tick();
        clr(); addr_sel = 1; mem_we_c = 1; #1;
        chk("R5 store address", mem_addr, ea);
        chk("R6 store data", mem_wdata, bv);
        chk("R6 write strobe", {31'd0, mem_we}, 32'd1);
        tick();
        mmem[ea[7:2]] = bv;
      end
      OP_BEQ: begin
        clr(); alu_a_sel = 1; alu_mode = 2'b01; pc_we_cond = 1; pc_src = 2'b01; #1;
        chk("R9 zero flag", {31'd0, zero}, {31'd0, av == bv});
        tick();
        if (av == bv) mpc = mpc + (sx << 2);
      end
      default: begin // OP_J
        clr(); pc_we = 1; pc_src = 2'b10; tick();
        mpc = {mpc[31:28], ins[25:0], 2'b00};
      end
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    clr();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[0]  = i_ins(OP_ORI, 0, 1, 16'h0080);           // R4
    mem[1]  = i_ins(OP_ORI, 0, 2, 16'hFFFF);           // R4 zero-extend
    mem[2]  = i_ins(OP_LW, 1, 3, 16'd4);               // R7 load via MDR
    mem[3]  = r_ins(3, 2, 4, F_ADD);
    mem[4]  = i_ins(OP_LW, 1, 5, 16'd8);
    mem[5]  = r_ins(5, 2, 6, F_ADD);                   // R3 wrap to 0xFFFE
    mem[6]  = r_ins(0, 2, 7, F_SUB);                   // R3 borrow
    mem[7]  = i_ins(OP_SW, 1, 6, 16'd12);
    mem[8]  = i_ins(OP_SW, 1, 7, 16'd16);
    mem[9]  = r_ins(2, 2, 0, F_ADD);                   // R8 write to r0
    mem[10] = i_ins(OP_SW, 1, 0, 16'd20);              // R8 r0 still zero
    mem[11] = i_ins(OP_BEQ, 1, 2, 16'd5);              // R9 not taken
    mem[12] = i_ins(OP_BEQ, 6, 6, 16'd2);              // R9 taken
    mem[13] = i_ins(OP_SW, 1, 2, 16'd24);
    mem[14] = i_ins(OP_SW, 1, 2, 16'd28);
    mem[15] = i_ins(OP_LW, 1, 8, 16'hFFFC);            // R5 negative offset
    mem[16] = i_ins(OP_SW, 1, 8, 16'd32);
    mem[17] = {OP_J, 26'd20};                          // R10
    mem[18] = i_ins(OP_SW, 1, 2, 16'd36);
    mem[19] = i_ins(OP_SW, 1, 2, 16'd40);
    mem[20] = i_ins(OP_ORI, 3, 9, 16'h8001);           // R4 OR
    mem[21] = i_ins(OP_SW, 1, 9, 16'd44);
    mem[22] = i_ins(OP_SW, 1, 4, 16'd48);              // R7 rd destination
    mem[31] = 32'h1234_5678;
    mem[33] = 32'h7FFF_FFFF;
    mem[34] = 32'hFFFF_FFFF;
    for (int i = 0; i < 64; i++) mmem[i] = mem[i];
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    mpc = 32'h0;

    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset address", mem_addr, 32'h0);
    chk("R1 reset opcode", {26'd0, opcode}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int n = 0; n < 40 && mpc != 32'd92; n++) run_one();

    clr(); #1;
    chk("R2 final address", mem_addr, mpc);
    for (int i = 32; i < 64; i++) chk("R6 data memory image", mem[i], mmem[i]);
    summary();
    $finish;
  end
endmodule